// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns active-low external interrupt pins into interrupt requests for an interrupt controller. Each pin passes through a two-flop synchronizer. After that, a per-source trigger-select bit chooses one of two modes:

- **Level mode:** the request follows the synchronized pin and is active while the pin is low.
- **Falling-edge mode:** a high-to-low transition sets a latched pending flag, and that flag is the request.

Software reads and writes a small control nibble. It holds one trigger-select bit and one pending bit per source.

The interrupt controller drives two inputs per source:

- a service-active level, which tells the block that the source's handler is running, so new edges on that pin are ignored;
- a one-cycle return-from-interrupt pulse, which clears the latched flag when the handler finishes.

The parameter `NUM_SRC` sets the number of sources; the default is two.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset, every trigger-select bit and every pending bit is 0, and `irq_req` is all zeros while the pins are high.
- R2: Control nibble layout: bit 2i is the trigger-select of source i (1 = falling edge, 0 = low level) and bit 2i+1 is its pending bit. A write with `ctl_wr_en` updates the trigger-select bits, and they read back on `ctl_rd_data` from the next cycle. Only software writes change them.
- R3: In level mode, `irq_req[i]` and pending bit 2i+1 on read both equal the inverse of the pin as it was two clock edges earlier. Nothing is held after the pin returns high.
- R4: In edge mode, a pin falling between two edges sets the pending flag at the third rising clock edge after the fall. The flag stays set after the pin returns high, and `irq_req[i]` equals the flag.
- R5: In edge mode, a falling edge whose detection cycle has `svc_active[i]` high does not set the flag of source i.
- R6: In edge mode, a `reti_pulse[i]` clears the pending flag of source i at the next clock edge.
- R7: In edge mode, a software write stores bit 2i+1 into the pending flag. If a hardware set lands in the same cycle as a write of 0, the flag ends up set.
- R8: In level mode, software writes to the pending bit have no effect. Changing a source to level mode drops its stored flag.
- R9: A pin held low in edge mode produces only one set. After a clear, the flag stays clear until the pin goes high and falls again.
- R10: Sources are independent: service, return and edges of one source never alter another source's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_n | input | NUM_SRC | Active-low external interrupt pins (asynchronous) |
| ctl_wr_en | input | 1 | Software write strobe for the control nibble |
| ctl_wr_data | input | 2*NUM_SRC | Write data: trigger-select at bit 2i, pending at bit 2i+1 |
| ctl_rd_data | output | 2*NUM_SRC | Read data of the control nibble |
| svc_active | input | NUM_SRC | High while the source's service routine runs |
| reti_pulse | input | NUM_SRC | One-cycle return-from-interrupt pulse per source |
| irq_req | output | NUM_SRC | Interrupt request per source to the controller |

## Verification
A wrong stored trigger-select bit shows on the next cycle in two ways: bit 2i of the read data is wrong, and the request switches between following the pin and holding a latched value. A wrong pending flag in edge mode appears on `irq_req` in the cycle after the faulty edge, because the request is driven straight from that flag. A wrong edge-detector history shows as an extra set or a missing set. The earliest point to see it is the third rising edge after the pin changes, so the checks sample three and five cycles after each stimulus.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    // Per-source control state: trigger select and latched pending flag
    typedef struct packed {
        logic trig_edge;
        logic pend;
    } src_state_t;

    // Edge detector history
    typedef struct packed {
        logic prev;
    } edge_state_t;

    // Field positions inside the control nibble
    function automatic int unsigned trig_bit(input int unsigned src);
        return 2 * src;
    endfunction

    function automatic int unsigned pend_bit(input int unsigned src);
        return 2 * src + 1;
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    always_comb begin
        chain_d    = chain_q;
        chain_d[0] = din;
        for (int unsigned k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[LAST];
endmodule

// File: rtl/ext_irq_edge_det.sv
module ext_irq_edge_det
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync,
    output logic fall
);
    edge_state_t st_d;
    edge_state_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // High in the previous sample, low in the current one
    assign fall = st_q.prev & ~pin_sync;
endmodule

// File: rtl/ext_irq_src.sv
module ext_irq_src
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync,
    input  logic fall,
    input  logic wr_en,
    input  logic wr_trig,
    input  logic wr_pend,
    input  logic svc_active,
    input  logic reti,
    output logic trig_edge,
    output logic req
);
    src_state_t st_d;
    src_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.trig_edge = wr_trig;
        end
        if (!st_d.trig_edge) begin
            // level mode stores nothing
            st_d.pend = 1'b0;
        end else begin
            if (wr_en) begin
                st_d.pend = wr_pend;
            end
            if (reti) begin
                st_d.pend = 1'b0;
            end
            if (fall && !svc_active) begin
                st_d.pend = 1'b1;  // hardware set has the last word
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_edge = st_q.trig_edge;
    assign req       = st_q.trig_edge ? st_q.pend : ~pin_sync;
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
    import ext_irq_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_SRC-1:0]     pin_n,
    input  logic                   ctl_wr_en,
    input  logic [2*NUM_SRC-1:0]   ctl_wr_data,
    output logic [2*NUM_SRC-1:0]   ctl_rd_data,
    input  logic [NUM_SRC-1:0]     svc_active,
    input  logic [NUM_SRC-1:0]     reti_pulse,
    output logic [NUM_SRC-1:0]     irq_req
);
    localparam int unsigned REG_W = 2 * NUM_SRC;

    logic [NUM_SRC-1:0] pin_sync;
    logic [NUM_SRC-1:0] fall;
    logic [NUM_SRC-1:0] trig_edge;
    logic [REG_W-1:0]   rd_d;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        ext_irq_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (1'b1)
        ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (pin_n[g]),
            .dout  (pin_sync[g])
        );

        ext_irq_edge_det u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_sync (pin_sync[g]),
            .fall     (fall[g])
        );

        ext_irq_src u_src (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_sync   (pin_sync[g]),
            .fall       (fall[g]),
            .wr_en      (ctl_wr_en),
            .wr_trig    (ctl_wr_data[trig_bit(g)]),
            .wr_pend    (ctl_wr_data[pend_bit(g)]),
            .svc_active (svc_active[g]),
            .reti       (reti_pulse[g]),
            .trig_edge  (trig_edge[g]),
            .req        (irq_req[g])
        );
    end

    always_comb begin
        rd_d = '0;
        for (int unsigned k = 0; k < NUM_SRC; k++) begin
            rd_d[trig_bit(k)] = trig_edge[k];
            rd_d[pend_bit(k)] = irq_req[k];
        end
    end

    assign ctl_rd_data = rd_d;
endmodule

// File: rtl/ext_irq_cond_chk.sv
module ext_irq_cond_chk #(
    parameter int unsigned NUM_SRC = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SRC-1:0]   pin_n,
    input logic                 ctl_wr_en,
    input logic [2*NUM_SRC-1:0] ctl_wr_data,
    input logic [2*NUM_SRC-1:0] ctl_rd_data,
    input logic [NUM_SRC-1:0]   svc_active,
    input logic [NUM_SRC-1:0]   reti_pulse,
    input logic [NUM_SRC-1:0]   irq_req
);
    logic [1:0] settle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (settle_q != 2'd3) begin
            settle_q <= settle_q + 2'd1;
        end
    end

    // R1
    initial_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctl_rd_data == '0));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        // R2
        trig_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_wr_en |=> ctl_rd_data[2*g] == $past(ctl_wr_data[2*g]));

        // R3
        level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (settle_q == 2'd3 && !ctl_rd_data[2*g]) |-> irq_req[g] == !$past(pin_n[g], 2));

        // R4
        pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_rd_data[2*g] && irq_req[g] && !reti_pulse[g] && !ctl_wr_en) |=> irq_req[g]);

        // R5
        svc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_rd_data[2*g] && !irq_req[g] && svc_active[g] && !ctl_wr_en) |=> !irq_req[g]);

        // R6
        reti_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_rd_data[2*g] && reti_pulse[g] && svc_active[g] && !ctl_wr_en) |=> !irq_req[g]);
    end
endmodule

bind ext_irq_cond ext_irq_cond_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_n       (pin_n),
    .ctl_wr_en   (ctl_wr_en),
    .ctl_wr_data (ctl_wr_data),
    .ctl_rd_data (ctl_rd_data),
    .svc_active  (svc_active),
    .reti_pulse  (reti_pulse),
    .irq_req     (irq_req)
);

// File: tb/ext_irq_cond_bench.sv
module ext_irq_cond_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin_n = 2'b11;
    logic       ctl_wr_en = 1'b0;
    logic [3:0] ctl_wr_data = 4'h0;
    logic [3:0] ctl_rd_data;
    logic [1:0] svc_active = 2'b00;
    logic [1:0] reti_pulse = 2'b00;
    logic [1:0] irq_req;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ext_irq_cond u_ext_irq_cond (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_n       (pin_n),
        .ctl_wr_en   (ctl_wr_en),
        .ctl_wr_data (ctl_wr_data),
        .ctl_rd_data (ctl_rd_data),
        .svc_active  (svc_active),
        .reti_pulse  (reti_pulse),
        .irq_req     (irq_req)
    );

    // {pin, wr, wdata, svc, reti, exp_irq, exp_rd}
    localparam int NV = 14;
    localparam logic [16:0] VEC [0:NV-1] = '{
        {2'b11, 1'b0, 4'b0000, 2'b00, 2'b00, 2'b00, 4'b0000},
        {2'b10, 1'b0, 4'b0000, 2'b00, 2'b00, 2'b01, 4'b0010},
        {2'b11, 1'b0, 4'b0000, 2'b00, 2'b00, 2'b00, 4'b0000},
        {2'b11, 1'b1, 4'b0101, 2'b00, 2'b00, 2'b00, 4'b0101},
        {2'b10, 1'b0, 4'b0000, 2'b00, 2'b00, 2'b01, 4'b0111},
        {2'b11, 1'b0, 4'b0000, 2'b00, 2'b00, 2'b01, 4'b0111},
        {2'b11, 1'b0, 4'b0000, 2'b00, 2'b01, 2'b00, 4'b0101},
        {2'b01, 1'b0, 4'b0000, 2'b10, 2'b00, 2'b00, 4'b0101},
        {2'b01, 1'b0, 4'b0000, 2'b00, 2'b00, 2'b00, 4'b0101},
        {2'b11, 1'b0, 4'b0000, 2'b00, 2'b00, 2'b00, 4'b0101},
        {2'b01, 1'b0, 4'b0000, 2'b00, 2'b00, 2'b10, 4'b1101},
        {2'b01, 1'b1, 4'b0001, 2'b00, 2'b00, 2'b10, 4'b1001},
        {2'b11, 1'b1, 4'b1011, 2'b00, 2'b00, 2'b01, 4'b0011},
        {2'b11, 1'b1, 4'b0001, 2'b00, 2'b00, 2'b00, 4'b0001}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:       return "R1";
            1, 2:    return "R3";
            3:       return "R2";
            4, 5:    return "R4";
            6:       return "R6";
            7:       return "R5";
            8, 9:    return "R9";
            10:      return "R10";
            11:      return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        wait_ticks(3);
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1", ctl_rd_data, 4'b0000);
        check("R1", {2'b00, irq_req}, 4'b0000);

        for (int i = 0; i < NV; i++) begin
            pin_n       = VEC[i][16:15];
            ctl_wr_en   = VEC[i][14];
            ctl_wr_data = VEC[i][13:10];
            svc_active  = VEC[i][9:8];
            reti_pulse  = VEC[i][7:6];
            tick();
            ctl_wr_en  = 1'b0;
            reti_pulse = 2'b00;
            wait_ticks(4);
            check(vec_tag(i), {2'b00, irq_req}, {2'b00, VEC[i][5:4]});
            check(vec_tag(i), ctl_rd_data, VEC[i][3:0]);
            svc_active = 2'b00;
        end

        // R4 latency: source 0 in edge mode, flag clear
        pin_n = 2'b10;
        tick();
        check("R4", {3'b000, irq_req[0]}, 4'b0000);
        tick();
        check("R4", {3'b000, irq_req[0]}, 4'b0000);
        tick();
        check("R4", {3'b000, irq_req[0]}, 4'b0001);
        pin_n = 2'b11;
        reti_pulse = 2'b01;
        tick();
        reti_pulse = 2'b00;
        wait_ticks(3);
        // R6 clear seen
        check("R6", {3'b000, irq_req[0]}, 4'b0000);

        // R7 hardware set wins over a write of 0 in the same cycle
        pin_n = 2'b10;
        wait_ticks(2);
        ctl_wr_en   = 1'b1;
        ctl_wr_data = 4'b0001;
        tick();
        ctl_wr_en = 1'b0;
        check("R7", {3'b000, irq_req[0]}, 4'b0001);

        // R9 pin held low: cleared flag stays clear
        reti_pulse = 2'b01;
        tick();
        reti_pulse = 2'b00;
        wait_ticks(5);
        check("R9", {3'b000, irq_req[0]}, 4'b0000);
        pin_n = 2'b11;
        wait_ticks(3);

        // R10 servicing source 1 does not block source 0
        ctl_wr_en   = 1'b1;
        ctl_wr_data = 4'b0101;
        tick();
        ctl_wr_en  = 1'b0;
        svc_active = 2'b10;
        pin_n      = 2'b10;
        wait_ticks(4);
        check("R10", {2'b00, irq_req}, 4'b0001);
        svc_active = 2'b00;
        pin_n      = 2'b11;
        reti_pulse = 2'b11;
        tick();
        reti_pulse = 2'b00;
        wait_ticks(2);

        // R10 simultaneous edges on both sources
        pin_n = 2'b00;
        wait_ticks(4);
        check("R10", {2'b00, irq_req}, 4'b0011);
        check("R10", ctl_rd_data, 4'b1111);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule